// File: doc/BRIEF.md
# Segment Relocation Unit with Split Program and Data Limits

This block turns logical addresses into physical ones for a processor that relocates whole segments. Instruction fetches and data accesses each have their own pair of relocation registers: a base, which is added to the logical address, and a limit, which gives the segment length. A logical address at or beyond the limit is a segment violation. The physical address is still presented, but the matching valid output stays low so no memory request leaves the block.

The four relocation registers are loaded through a single write port. The port only accepts a write while the supervisor mode input is high. A write attempted in user mode leaves every register unchanged and raises a one-cycle privilege error pulse. All registers reset to zero, so every access violates until supervisor code has configured the segments. Results are registered: the inputs sampled at a clock edge appear at the outputs after that edge. A register write at the same edge affects only later accesses.

Top module: `seg_relocator`

## Requirements
- R1: One cycle after an edge, fetchPhys equals the program base plus the fetchAddr sampled at that edge, taken modulo 2^ADDR_W.
- R2: One cycle after an edge, dataPhys equals the data base plus the dataAddr sampled at that edge, modulo 2^ADDR_W. This holds whether or not dataValid is high.
- R3: fetchFault is 1 exactly when the sampled fetchAddr is greater than or equal to the program limit, so an address equal to the limit faults. fetchValid is the inverse of fetchFault.
- R4: When dataValid is sampled high, dataFault is 1 exactly when dataAddr is greater than or equal to the data limit, and dataValidOut is its inverse. When dataValid is sampled low, dataValidOut and dataFault are both 0.
- R5: Program registers affect only the fetch outputs, and data registers affect only the data outputs.
- R6: A write with cfgWrEn=1 and supervisorMode=1 loads cfgData into the register chosen by cfgSel: 0 is program base, 1 is program limit, 2 is data base, 3 is data limit. The new value is used by accesses sampled from the next edge on, not by the access sampled at the write edge.
- R7: A write with cfgWrEn=1 and supervisorMode=0 changes no register. privError is 1 during the cycle after that edge and 0 after any edge without such a write.
- R8: Reset (rstN low) clears all four registers and all outputs to 0. Until the registers are written, every fetch and every valid data access therefore faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supervisorMode | input | 1 | 1 = supervisor, 0 = user |
| fetchAddr | input | ADDR_W | Logical instruction fetch address |
| dataAddr | input | ADDR_W | Logical data address |
| dataValid | input | 1 | Data access request strobe |
| cfgWrEn | input | 1 | Relocation register write strobe |
| cfgSel | input | 2 | Register select (0 prog base, 1 prog limit, 2 data base, 3 data limit) |
| cfgData | input | ADDR_W | Register write value |
| fetchPhys | output | ADDR_W | Relocated fetch address |
| fetchValid | output | 1 | Fetch is inside its segment |
| fetchFault | output | 1 | Fetch segment violation |
| dataPhys | output | ADDR_W | Relocated data address |
| dataValidOut | output | 1 | Data request may be issued |
| dataFault | output | 1 | Data segment violation |
| privError | output | 1 | Pulse after a user-mode register write attempt |

## Verification
The assertions check on every cycle that a fault and its valid output are never high together and that the fetch pair is always complementary. They also check that an idle data slot produces neither a fault nor a valid output, and that privError follows exactly the user-mode write attempts. Only the bench's scenarios can show the translated address values: the limit boundary at and just below the limit, wraparound of the base addition, the timing of a write relative to a same-cycle access, the independence of the two segments, and that a refused user write leaves the translation unchanged.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_FETCH = 0;
  localparam int CH_DATA = 1;

  typedef struct packed {
    logic [NUM_CH-1:0] wrBase;
    logic [NUM_CH-1:0] wrLimit;
    logic              privErr;
  } relocStrobes_t;
endpackage

// File: rtl/reloc_channel.sv
module reloc_channel #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] logAddr,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] limitReg,
  output logic [ADDR_W-1:0] physAddr,
  output logic              okOut,
  output logic              faultOut
);
  logic [ADDR_W-1:0] sumNext;
  logic              outside;

  always_comb begin
    sumNext = baseReg + logAddr;
    outside = (logAddr >= limitReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr <= '0;
      okOut    <= 1'b0;
      faultOut <= 1'b0;
    end else begin
      physAddr <= sumNext;
      okOut    <= reqValid && !outside;
      faultOut <= reqValid && outside;
    end
  end
endmodule

// File: rtl/reloc_ctrl.sv
module reloc_ctrl
  import reloc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          supervisorMode,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgSel,
  output relocStrobes_t strobes,
  output logic          privError
);
  logic allowed;
  logic chSel;

  always_comb begin
    allowed = cfgWrEn && supervisorMode;
    chSel   = cfgSel[1];
    strobes = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strobes.wrBase[ch]  = allowed && (chSel == ch[0]) && !cfgSel[0];
      strobes.wrLimit[ch] = allowed && (chSel == ch[0]) && cfgSel[0];
    end
    strobes.privErr = cfgWrEn && !supervisorMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privError <= 1'b0;
    else       privError <= strobes.privErr;
  end
endmodule

// File: rtl/reloc_datapath.sv
module reloc_datapath
  import reloc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  relocStrobes_t                  strobes,
  input  logic [ADDR_W-1:0]              cfgData,
  input  logic [NUM_CH-1:0]              chValid,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  chAddr,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  chPhys,
  output logic [NUM_CH-1:0]              chOk,
  output logic [NUM_CH-1:0]              chFault
);
  logic [NUM_CH-1:0][ADDR_W-1:0] baseR;
  logic [NUM_CH-1:0][ADDR_W-1:0] limitR;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseR[ch]  <= '0;
        limitR[ch] <= '0;
      end else begin
        if (strobes.wrBase[ch])  baseR[ch]  <= cfgData;
        if (strobes.wrLimit[ch]) limitR[ch] <= cfgData;
      end
    end

    reloc_channel #(.ADDR_W(ADDR_W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .reqValid (chValid[ch]),
      .logAddr  (chAddr[ch]),
      .baseReg  (baseR[ch]),
      .limitReg (limitR[ch]),
      .physAddr (chPhys[ch]),
      .okOut    (chOk[ch]),
      .faultOut (chFault[ch])
    );
  end
endmodule

// File: rtl/seg_relocator.sv
module seg_relocator
  import reloc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supervisorMode,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              dataValid,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] fetchPhys,
  output logic              fetchValid,
  output logic              fetchFault,
  output logic [ADDR_W-1:0] dataPhys,
  output logic              dataValidOut,
  output logic              dataFault,
  output logic              privError
);
  relocStrobes_t                 strobes;
  logic [NUM_CH-1:0]             chValid;
  logic [NUM_CH-1:0][ADDR_W-1:0] chAddr;
  logic [NUM_CH-1:0][ADDR_W-1:0] chPhys;
  logic [NUM_CH-1:0]             chOk;
  logic [NUM_CH-1:0]             chFault;

  always_comb begin
    chValid[CH_FETCH] = 1'b1;
    chValid[CH_DATA]  = dataValid;
    chAddr[CH_FETCH]  = fetchAddr;
    chAddr[CH_DATA]   = dataAddr;
  end

  reloc_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .supervisorMode (supervisorMode),
    .cfgWrEn        (cfgWrEn),
    .cfgSel         (cfgSel),
    .strobes        (strobes),
    .privError      (privError)
  );

  reloc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cfgData (cfgData),
    .chValid (chValid),
    .chAddr  (chAddr),
    .chPhys  (chPhys),
    .chOk    (chOk),
    .chFault (chFault)
  );

  assign fetchPhys    = chPhys[CH_FETCH];
  assign fetchValid   = chOk[CH_FETCH];
  assign fetchFault   = chFault[CH_FETCH];
  assign dataPhys     = chPhys[CH_DATA];
  assign dataValidOut = chOk[CH_DATA];
  assign dataFault    = chFault[CH_DATA];
endmodule

// File: rtl/seg_relocator_checker.sv
module seg_relocator_checker (
  input logic clk,
  input logic rstN,
  input logic supervisorMode,
  input logic dataValid,
  input logic cfgWrEn,
  input logic fetchValid,
  input logic fetchFault,
  input logic dataValidOut,
  input logic dataFault,
  input logic privError
);
  assert_fetch_complement_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (fetchValid != fetchFault));

  assert_data_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(dataValidOut && dataFault));

  assert_data_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> (!dataValidOut && !dataFault));

  assert_user_write_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !supervisorMode) |=> privError);

  assert_no_spurious_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && !supervisorMode) |=> !privError);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rstN |-> (!fetchValid && !fetchFault && !dataValidOut && !dataFault && !privError));
endmodule

bind seg_relocator seg_relocator_checker u_checker (
  .clk            (clk),
  .rstN           (rstN),
  .supervisorMode (supervisorMode),
  .dataValid      (dataValid),
  .cfgWrEn        (cfgWrEn),
  .fetchValid     (fetchValid),
  .fetchFault     (fetchFault),
  .dataValidOut   (dataValidOut),
  .dataFault      (dataFault),
  .privError      (privError)
);

// File: tb/seg_relocator_bench.sv
module seg_relocator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          supervisorMode = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic [AW-1:0] dataAddr = '0;
  logic          dataValid = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [AW-1:0] cfgData = '0;
  logic [AW-1:0] fetchPhys;
  logic          fetchValid;
  logic          fetchFault;
  logic [AW-1:0] dataPhys;
  logic          dataValidOut;
  logic          dataFault;
  logic          privError;

  seg_relocator #(.ADDR_W(AW)) u_seg_relocator (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [AW-1:0] fPhys;
    logic          fValid;
    logic          fFault;
    logic [AW-1:0] dPhys;
    logic          dValid;
    logic          dFault;
    logic          priv;
    string         note;
  } expItem_t;

  expItem_t      scoreQ[$];
  logic [AW-1:0] mReg[4];
  int            checks = 0;
  int            fails = 0;
  bit            finished = 0;

  task automatic chk(input logic [AW-1:0] act, input logic [AW-1:0] exp,
                     input string req, input string note);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual %h expected %h", req, note, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus at the falling edge and predicts the result.
  // cfgSel: 0 prog base, 1 prog limit, 2 data base, 3 data limit.
  task automatic drive(input logic sup, input logic [AW-1:0] fa, input logic [AW-1:0] da,
                       input logic dv, input logic we, input logic [1:0] sel,
                       input logic [AW-1:0] wd, input string note);
    expItem_t it;
    @(negedge clk);
    supervisorMode = sup; fetchAddr = fa; dataAddr = da; dataValid = dv;
    cfgWrEn = we; cfgSel = sel; cfgData = wd;
    it.fPhys  = mReg[0] + fa;
    it.fFault = (fa >= mReg[1]);
    it.fValid = !it.fFault;
    it.dPhys  = mReg[2] + da;
    it.dFault = dv && (da >= mReg[3]);
    it.dValid = dv && !(da >= mReg[3]);
    it.priv   = we && !sup;
    it.note   = note;
    scoreQ.push_back(it);
    if (we && sup) mReg[sel] = wd;
  endtask

  // Monitor: compares each prediction a quarter period after the edge that produced it.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rstN && scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        chk(fetchPhys, e.fPhys, "R1", e.note);
        chk({31'b0, fetchFault}, {31'b0, e.fFault}, "R3", e.note);
        chk({31'b0, fetchValid}, {31'b0, e.fValid}, "R3", e.note);
        chk(dataPhys, e.dPhys, "R2", e.note);
        chk({31'b0, dataFault}, {31'b0, e.dFault}, "R4", e.note);
        chk({31'b0, dataValidOut}, {31'b0, e.dValid}, "R4", e.note);
        chk({31'b0, privError}, {31'b0, e.priv}, "R7", e.note);
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mReg[i] = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R8: outputs cleared while in reset
    chk(fetchPhys, '0, "R8", "reset fetchPhys");
    chk({31'b0, fetchFault | fetchValid}, '0, "R8", "reset fetch flags");
    chk({31'b0, dataFault | dataValidOut | privError}, '0, "R8", "reset data flags");
    @(negedge clk);
    rstN = 1'b1;

    // R8: unconfigured registers make every access fault
    drive(1, 32'h0, 32'h0, 1, 0, 0, 0, "R8 unconfigured zero addr");
    drive(1, 32'h1234, 32'h55, 1, 0, 0, 0, "R8 unconfigured nonzero");
    // R6: write with same-cycle access uses the old values
    drive(1, 32'h5, 32'h0, 0, 1, 2'd0, 32'h1000, "R6 prog base write, old used");
    drive(1, 32'h5, 32'h0, 0, 1, 2'd1, 32'h100, "R6 prog limit write");
    drive(1, 32'h5, 32'h3, 1, 1, 2'd2, 32'h8000, "R6 data base write");
    drive(1, 32'h5, 32'h3, 1, 1, 2'd3, 32'h40, "R6 data limit write");
    // R1/R2 normal translation
    drive(0, 32'h10, 32'h3f, 1, 0, 0, 0, "R1 R2 inside both segments");
    drive(0, 32'hff, 32'h0, 1, 0, 0, 0, "R3 one below limit");
    drive(0, 32'h100, 32'h40, 1, 0, 0, 0, "R3 R4 exactly at limit");
    drive(0, 32'h7777, 32'h41, 1, 0, 0, 0, "R3 R4 far beyond limit");
    // R4: idle data slot
    drive(0, 32'h20, 32'h99, 0, 0, 0, 0, "R4 data idle");
    // R7: user-mode writes ignored
    drive(0, 32'h20, 32'h10, 1, 1, 2'd0, 32'h2000, "R7 user write prog base");
    drive(0, 32'h20, 32'h10, 1, 1, 2'd3, 32'hffff, "R7 user write data limit");
    drive(0, 32'h20, 32'h3f, 1, 0, 0, 0, "R7 after refused writes");
    drive(0, 32'h20, 32'h3f, 1, 0, 0, 0, "R7 pulse ends");
    // R5: data register changes leave fetch outputs alone, and vice versa
    drive(1, 32'h30, 32'h8, 1, 1, 2'd2, 32'hA000, "R5 data base change");
    drive(1, 32'h30, 32'h8, 1, 1, 2'd3, 32'h0, "R5 data limit to zero");
    drive(1, 32'h30, 32'h8, 1, 1, 2'd1, 32'h10, "R5 prog limit shrinks");
    drive(1, 32'h30, 32'h8, 1, 0, 0, 0, "R5 after both changes");
    // R1 wraparound of the base addition
    drive(1, 32'h0, 32'h0, 0, 1, 2'd0, 32'hFFFF_FFF0, "R6 base near top");
    drive(1, 32'h0, 32'h0, 0, 1, 2'd1, 32'hFFFF_FFFF, "R6 limit to max");
    drive(1, 32'h20, 32'h0, 0, 0, 0, 0, "R1 wraparound");
    drive(1, 32'hFFFF_FFFF, 32'h0, 0, 0, 0, 0, "R3 max addr at max limit");
    drive(1, 32'h0, 32'h0, 0, 0, 0, 0, "drain");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule